// File: doc/BRIEF.md
# Register Transfer Command Executor

This block sits behind a simple command sequencer and carries out two register-transfer commands taken from a stream of 32-bit words. The first word of each command is a header. It holds an opcode, a count and a starting register number. A load command copies the data words that follow it into consecutive internal registers. A store command reads one internal register and sends its value as a memory write request. The memory address for that request is the word that follows the header.

Every command is checked against a parameterised map of the registers that exist. If a command refers to a missing register, the block does not carry it out. It still consumes the command's remaining words, so the next word it decodes is a real header. It then raises a sticky error flag for the task that issued the command, and pulses an interrupt if that task has its interrupt enabled.

Both streams use valid/ready handshakes. A word moves on `cmd_valid && cmd_ready`, and a memory write moves on `mem_wr_valid && mem_wr_ready`. `cmd_ready` is high in every state except one: while a store write waits for `mem_wr_ready`, the command input is back-pressured. During that wait, `mem_wr_valid`, the address and the data stay unchanged. A header whose opcode is not handled is reported on a separate strobe and takes no further words.

Top module: `regprog_xfer_exec`

## Requirements
- R1: Header decode uses only these fields. Bits 31:28 are the opcode: 4'b1001 means load and 4'b1010 means store. Bits 15:8 are the count. Bits 6:0 are the register number. Bits 27:16 and bit 7 have no effect.
- R2: A load with count N consumes N data words. Data word k writes register (number + k), with `reg_wr_en` high in the cycle that word is accepted.
- R3: A count of zero turns a load or a store into a one-word no-op. It causes no register access, no memory write and no error.
- R4: A store uses exactly two words. When the second word is accepted, `reg_rd_en` pulses with `reg_rd_addr` set to the register number. A memory write request then carries that word as its address and the register value as its data. For a store, any nonzero count selects only the one register.
- R5: While `mem_wr_valid` is high, `cmd_ready` is low. If `mem_wr_ready` is low, valid, address and data hold their values into the next cycle. The cycle after the write is accepted, a new header can be accepted.
- R6: A load is rejected if any register in its range is missing from the valid map or lies above register 127. All of its data words are still consumed, and none is written.
- R7: A store to a missing register consumes its address word but performs no register read and no memory write.
- R8: On the clock edge that accepts a rejected header, `rd_err[task]` is set, where task is `cmd_task` at that edge. The flag stays set until `err_clr[task]` is high at a clock edge. If a set and a clear for the same task fall on the same edge, the set wins.
- R9: `irq` is a one-cycle pulse in the cycle after a rejected header, and only when `err_irq_en[task]` is set.
- R10: A header with any other opcode produces a one-cycle `unk_stb` in the following cycle, with `unk_word` equal to that header. The next word is decoded as a header.
- R11: After reset, `cmd_ready` is 1, and `reg_wr_en`, `reg_rd_en`, `mem_wr_valid`, `irq`, `unk_stb` and `rd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high together with valid |
| cmd_word | input | 32 | Command word |
| cmd_task | input | TASK_W | Task issuing the current word |
| err_irq_en | input | NUM_TASKS | Per-task interrupt enable |
| err_clr | input | NUM_TASKS | Per-task error flag clear |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 7 | Register write number |
| reg_wr_data | output | 32 | Register write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_addr | output | 7 | Register read number |
| reg_rd_data | input | 32 | Register read data, same-cycle |
| mem_wr_valid | output | 1 | Memory write request valid |
| mem_wr_ready | input | 1 | Memory write request accepted |
| mem_wr_addr | output | 32 | Memory write address |
| mem_wr_data | output | 32 | Memory write data |
| rd_err | output | NUM_TASKS | Sticky per-task error flags |
| irq | output | 1 | Error interrupt pulse |
| unk_stb | output | 1 | Unhandled header strobe |
| unk_word | output | 32 | Unhandled header word |

## Verification
If the word counter or the phase register goes wrong, the stream falls out of step. A data word then gets decoded as a header, which shows up as a stray `unk_stb` or a register write that was not expected, usually within one or two words. If the register number is not advanced correctly, the wrong address appears on `reg_wr_addr` at the very next data word. A wrong rejection decision becomes visible one cycle after the header, on `rd_err` and `irq`. If a store's data is captured badly, the error surfaces only when the memory write handshake completes, which can be delayed by back-pressure cycles.

// File: rtl/regprog_pkg.sv
package regprog_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 7;
  localparam int NREG   = 1 << REG_AW;
  localparam int LEN_W  = 8;

  localparam logic [3:0] OPC_LOAD  = 4'b1001;
  localparam logic [3:0] OPC_STORE = 4'b1010;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_LOAD,
    PH_SADDR,
    PH_SWAIT
  } phase_e;

  typedef struct packed {
    logic              is_load;
    logic              is_store;
    logic              is_other;
    logic              zero_len;
    logic [LEN_W-1:0]  len;
    logic [REG_AW-1:0] regno;
  } hdr_t;
endpackage

// File: rtl/rpx_hdr_decode.sv
module rpx_hdr_decode
  import regprog_pkg::*;
(
  input  logic [3:0]        opc,
  input  logic [LEN_W-1:0]  len,
  input  logic [REG_AW-1:0] regno,
  output hdr_t              hdr
);
  always_comb begin
    hdr.is_load  = (opc == OPC_LOAD);
    hdr.is_store = (opc == OPC_STORE);
    hdr.is_other = !hdr.is_load && !hdr.is_store;
    hdr.zero_len = (len == '0);
    hdr.len      = len;
    hdr.regno    = regno;
  end
endmodule

// File: rtl/rpx_range_check.sv
module rpx_range_check
  import regprog_pkg::*;
#(
  parameter logic [NREG-1:0] VALID_MASK = '1
) (
  input  logic [REG_AW-1:0] first,
  input  logic [LEN_W-1:0]  count,
  output logic              ok
);
  localparam int END_W = LEN_W + 1;

  logic [END_W-1:0] last;
  logic [NREG-1:0]  hole;

  assign last = END_W'(first) + END_W'(count) - END_W'(1);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hole[i] = (END_W'(i) >= END_W'(first)) &&
                     (END_W'(i) <= last) && !VALID_MASK[i];
  end

  assign ok = (last <= END_W'(NREG - 1)) && (hole == '0);
endmodule

// File: rtl/rpx_err_flags.sv
module rpx_err_flags #(
  parameter int NUM_TASKS = 2,
  localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_vld,
  input  logic [TASK_W-1:0]    set_task,
  input  logic [NUM_TASKS-1:0] irq_en,
  input  logic [NUM_TASKS-1:0] clr,
  output logic [NUM_TASKS-1:0] flags,
  output logic                 irq
);
  logic [NUM_TASKS-1:0] set_vec;

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    assign set_vec[t] = set_vld && (set_task == TASK_W'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) flags[t] <= 1'b0;
      else        flags[t] <= (flags[t] && !clr[t]) || set_vec[t];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(set_vec & irq_en);
  end
endmodule

// File: rtl/regprog_xfer_exec.sv
module regprog_xfer_exec
  import regprog_pkg::*;
#(
  parameter int NUM_TASKS = 2,
  parameter logic [NREG-1:0] VALID_MASK =
    128'h0000_0000_FFF0_FFFF_FFFF_FFFF_FFFF_FFFF,
  localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [WORD_W-1:0]    cmd_word,
  input  logic [TASK_W-1:0]    cmd_task,
  input  logic [NUM_TASKS-1:0] err_irq_en,
  input  logic [NUM_TASKS-1:0] err_clr,
  output logic                 reg_wr_en,
  output logic [REG_AW-1:0]    reg_wr_addr,
  output logic [WORD_W-1:0]    reg_wr_data,
  output logic                 reg_rd_en,
  output logic [REG_AW-1:0]    reg_rd_addr,
  input  logic [WORD_W-1:0]    reg_rd_data,
  output logic                 mem_wr_valid,
  input  logic                 mem_wr_ready,
  output logic [WORD_W-1:0]    mem_wr_addr,
  output logic [WORD_W-1:0]    mem_wr_data,
  output logic [NUM_TASKS-1:0] rd_err,
  output logic                 irq,
  output logic                 unk_stb,
  output logic [WORD_W-1:0]    unk_word
);
  phase_e            ph_q;
  logic [LEN_W-1:0]  left_q;
  logic [REG_AW-1:0] regno_q;
  logic              skip_q;
  logic [WORD_W-1:0] maddr_q, mdata_q;

  hdr_t             hdr;
  logic             take, hdr_take, range_ok, reject;
  logic [LEN_W-1:0] chk_len;

  rpx_hdr_decode u_dec (
    .opc   (cmd_word[31:28]),
    .len   (cmd_word[15:8]),
    .regno (cmd_word[6:0]),
    .hdr   (hdr)
  );

  // A store covers exactly one register whatever its nonzero count.
  assign chk_len = hdr.is_store ? LEN_W'(1) : hdr.len;

  rpx_range_check #(.VALID_MASK(VALID_MASK)) u_rng (
    .first (hdr.regno),
    .count (chk_len),
    .ok    (range_ok)
  );

  assign cmd_ready = (ph_q != PH_SWAIT);
  assign take      = cmd_valid && cmd_ready;
  assign hdr_take  = take && (ph_q == PH_HDR);
  assign reject    = hdr_take && (hdr.is_load || hdr.is_store) &&
                     !hdr.zero_len && !range_ok;

  rpx_err_flags #(.NUM_TASKS(NUM_TASKS)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vld  (reject),
    .set_task (cmd_task),
    .irq_en   (err_irq_en),
    .clr      (err_clr),
    .flags    (rd_err),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_HDR;
      left_q  <= '0;
      regno_q <= '0;
      skip_q  <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
    end else begin
      unique case (ph_q)
        PH_HDR: if (take && !hdr.zero_len) begin
          regno_q <= hdr.regno;
          left_q  <= hdr.len;
          skip_q  <= !range_ok;
          if (hdr.is_load)       ph_q <= PH_LOAD;
          else if (hdr.is_store) ph_q <= PH_SADDR;
        end
        PH_LOAD: if (take) begin
          regno_q <= regno_q + 1'b1;
          left_q  <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) ph_q <= PH_HDR;
        end
        PH_SADDR: if (take) begin
          if (skip_q) begin
            ph_q <= PH_HDR;
          end else begin
            maddr_q <= cmd_word;
            mdata_q <= reg_rd_data;
            ph_q    <= PH_SWAIT;
          end
        end
        PH_SWAIT: if (mem_wr_ready) ph_q <= PH_HDR;
        default: ph_q <= PH_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unk_stb  <= 1'b0;
      unk_word <= '0;
    end else begin
      unk_stb <= hdr_take && hdr.is_other;
      if (hdr_take && hdr.is_other) unk_word <= cmd_word;
    end
  end

  assign reg_wr_en    = take && (ph_q == PH_LOAD) && !skip_q;
  assign reg_wr_addr  = regno_q;
  assign reg_wr_data  = cmd_word;
  assign reg_rd_en    = take && (ph_q == PH_SADDR) && !skip_q;
  assign reg_rd_addr  = regno_q;
  assign mem_wr_valid = (ph_q == PH_SWAIT);
  assign mem_wr_addr  = maddr_q;
  assign mem_wr_data  = mdata_q;
endmodule

// File: rtl/rpx_checker.sv
module rpx_checker #(
  parameter int NUM_TASKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 reg_wr_en,
  input logic                 reg_rd_en,
  input logic                 mem_wr_valid,
  input logic                 mem_wr_ready,
  input logic [31:0]          mem_wr_addr,
  input logic [31:0]          mem_wr_data,
  input logic [NUM_TASKS-1:0] rd_err,
  input logic                 irq,
  input logic                 unk_stb
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  assert_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !cmd_ready);

  assert_wr_on_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> cmd_valid && cmd_ready);

  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, reg_rd_en, mem_wr_valid}));

  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_err != '0);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_unk_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unk_stb |-> $past(cmd_valid && cmd_ready));
endmodule

bind regprog_xfer_exec rpx_checker #(.NUM_TASKS(NUM_TASKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .rd_err       (rd_err),
  .irq          (irq),
  .unk_stb      (unk_stb)
);

// File: tb/sim_regprog_xfer_exec.sv
`timescale 1ns/100ps
module sim_regprog_xfer_exec;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready;
  logic [31:0] cmd_word = 0;
  logic        cmd_task = 0;
  logic [1:0]  err_irq_en = 2'b10, err_clr = 0;
  logic        reg_wr_en, reg_rd_en, mem_wr_valid, mem_wr_ready, irq, unk_stb;
  logic [6:0]  reg_wr_addr, reg_rd_addr;
  logic [31:0] reg_wr_data, reg_rd_data, mem_wr_addr, mem_wr_data, unk_word;
  logic [1:0]  rd_err;

  regprog_xfer_exec u0 (.*);

  logic [31:0] rf [128];
  logic [31:0] model_rf [128];
  logic [7:0]  lfsr = 8'h5A;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (reg_wr_en) rf[reg_wr_addr] <= reg_wr_data;
  end
  assign mem_wr_ready = lfsr[0] & lfsr[2];
  assign reg_rd_data  = rf[reg_rd_addr];

  int tests = 0, fails = 0, irq_seen = 0, irq_exp = 0;
  logic [1:0] exp_err = 0;
  int          wa_q[$];
  logic [31:0] wd_q[$], ma_q[$], md_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit reg_ok(input int a);
    return (a < 80) || (a >= 84 && a < 96);
  endfunction

  // monitor, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (reg_wr_en) begin
        if (wa_q.size() == 0) check(0, "R2 unexpected write", {25'd0, reg_wr_addr}, 0);
        else begin
          int a; logic [31:0] d;
          a = wa_q.pop_front(); d = wd_q.pop_front();
          check(reg_wr_addr == a[6:0] && reg_wr_data == d, "R2 write", reg_wr_data, d);
        end
      end
      if (mem_wr_valid) check(!cmd_ready, "R5 ready low", {31'd0, cmd_ready}, 0);
      if (mem_wr_valid && mem_wr_ready) begin
        if (ma_q.size() == 0) check(0, "R4 unexpected mem write", mem_wr_addr, 0);
        else begin
          logic [31:0] ea, ed;
          ea = ma_q.pop_front(); ed = md_q.pop_front();
          check(mem_wr_addr == ea, "R4 mem addr", mem_wr_addr, ea);
          check(mem_wr_data == ed, "R4 mem data", mem_wr_data, ed);
        end
      end
      if (irq) irq_seen++;
    end
  end

  task automatic send(input logic [31:0] w, input bit tk);
    cmd_word = w; cmd_task = tk; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic hdr_checks(input bit bad, input bit tk);
    check(rd_err == exp_err, "R8 flags", {30'd0, rd_err}, {30'd0, exp_err});
    check(irq == (bad && err_irq_en[tk]), "R9 irq", {31'd0, irq}, {31'd0, bad && err_irq_en[tk]});
    if (bad && err_irq_en[tk]) irq_exp++;
  endtask

  task automatic do_ld(input logic [31:0] hdr, input bit tk, input logic [31:0] seed, input int gap);
    int a, n; bit ok;
    a = hdr[6:0]; n = hdr[15:8]; ok = 1;
    for (int i = 0; i < n; i++) if (!reg_ok(a + i)) ok = 0;
    if (!ok) exp_err[tk] = 1;
    send(hdr, tk);
    hdr_checks(!ok, tk);
    for (int i = 0; i < n; i++) begin
      if (ok) begin wa_q.push_back(a + i); wd_q.push_back(seed + i); model_rf[a + i] = seed + i; end
      send(seed + i, tk);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic do_st(input logic [31:0] hdr, input bit tk, input logic [31:0] maddr);
    int a; bit ok;
    a = hdr[6:0]; ok = reg_ok(a);
    if (hdr[15:8] == 0) begin
      send(hdr, tk);
      hdr_checks(0, tk);
      check(cmd_ready && !mem_wr_valid, "R3 store nop", {31'd0, mem_wr_valid}, 0);
    end else begin
      if (!ok) exp_err[tk] = 1;
      else begin ma_q.push_back(maddr); md_q.push_back(model_rf[a]); end
      send(hdr, tk);
      hdr_checks(!ok, tk);
      send(maddr, tk);
      if (!ok) check(!mem_wr_valid && cmd_ready, "R7 no mem write", {31'd0, mem_wr_valid}, 0);
      while (ma_q.size() != 0) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin rf[i] = 0; model_rf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(cmd_ready && !reg_wr_en && !reg_rd_en && !mem_wr_valid && !irq && !unk_stb && rd_err == 0,
          "R11 reset", {26'd0, cmd_ready, reg_wr_en, mem_wr_valid, irq, rd_err}, 32'h20);

    // R1: reserved bits set, load 4 words into 3..6
    do_ld(32'h9ABC_0483, 0, 32'hA000_0011, 0);
    // R4: store register 4 with back-pressure
    do_st(32'hA000_0104, 0, 32'h1000_0040);
    // R3: zero counts
    do_ld(32'h9000_0005, 0, 0, 0);
    do_st(32'hA000_0003, 0, 32'hDEAD_BEEF);
    check(unk_stb == 0, "R3 nop no unk", {31'd0, unk_stb}, 0);
    // R2 with idle gaps, valid range up to 79
    do_ld(32'h9000_024E, 1, 32'h7700_0000, 2);
    // R6 + R9: range crosses missing 80..83, task 1 interrupt on
    do_ld(32'h9000_044E, 1, 32'h5500_0000, 1);
    do_st(32'hA000_014E, 1, 32'h2000_0000);
    // R6: beyond register 127, task 0 interrupt off
    do_ld(32'h9000_037E, 0, 32'h6600_0000, 0);
    // R2 boundary 84..95 valid, R6 95..96 rejected
    do_ld(32'h9000_0C54, 0, 32'hC000_0000, 1);
    do_ld(32'h9000_025F, 0, 32'hE000_0000, 0);
    // R7: store to missing register, then aligned valid store; R1 count 255 on store
    do_st(32'hA000_0152, 1, 32'h3000_0000);
    do_st(32'hAFFF_FFDF, 0, 32'h4000_0004);
    // R10: unhandled headers back to back
    send(32'h5123_4567, 0);
    check(unk_stb && unk_word == 32'h5123_4567, "R10 unk", unk_word, 32'h5123_4567);
    send(32'hB000_0101, 1);
    check(unk_stb && unk_word == 32'hB000_0101, "R10 unk2", unk_word, 32'hB000_0101);
    do_ld(32'h9000_0110, 0, 32'h1234_5678, 0);
    check(!unk_stb, "R10 strobe ends", {31'd0, unk_stb}, 0);
    // R8: clear task 0
    err_clr = 2'b01;
    @(negedge clk);
    err_clr = 0; exp_err[0] = 0;
    check(rd_err == exp_err, "R8 clear", {30'd0, rd_err}, {30'd0, exp_err});
    // R8: set wins over clear on the same edge
    cmd_word = 32'h9000_0152; cmd_task = 1; cmd_valid = 1; err_clr = 2'b10;
    @(negedge clk);
    cmd_valid = 0; err_clr = 0;
    hdr_checks(1, 1);
    send(32'hFFFF_0000, 1);
    // final cross-checks
    repeat (4) @(negedge clk);
    check(wa_q.size() == 0, "R2 writes drained", wa_q.size(), 0);
    check(ma_q.size() == 0, "R4 mem drained", ma_q.size(), 0);
    check(irq_seen == irq_exp, "R9 irq count", irq_seen, irq_exp);
    check(rd_err == exp_err, "R8 final", {30'd0, rd_err}, {30'd0, exp_err});
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule